// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block holds the byte-wide register file of one ATA channel that serves two drive slots. A host bus with a 4-bit register offset, a read strobe and a write strobe reaches the eight command-block registers, the device-control register and the alternate-address register. The block keeps a status byte, an error byte, a drive/head byte and, for each slot, its own copies of sector count, sector number and the two cylinder bytes. It runs the soft-reset sequence from edges of the reset bit in the control register. It executes a small set of register-level commands and pulses an interrupt request when a command completes.

Two inputs tell the block what sits in each slot: nothing, a disk, or a packet device. Reads addressed to an empty slot return fixed values. Identify commands check the device type before they answer. The last command byte and the block size of the selected slot are driven out for the data path, which lies outside this block. Sector data, packet parsing and DMA are also outside this block.

Top module: `ata_taskfile`

## Requirements
- R1: After power-on reset, with the selected slot present, status reads 0x00, error reads 0x01, drive/head reads 0x00, the command output is 0x00, the interrupt is enabled and the selected block size is 1.
- R2: A control write (offset 8) that takes bit 2 (soft reset) from 0 to 1 sets status to 0x90, error to 0x01 and the command output to 0x00, and clears bit 1 (interrupt disable) whatever value was written. A control write that leaves bit 2 at 1 does not repeat the reset.
- R3: A control write that takes bit 2 from 1 to 0 clears status bit 7 (busy), sets status bit 6 (ready) and zeroes drive/head bits 3:0. In both slots it sets sector count and sector number to 1. It sets the cylinder to 0xEB14 (high byte offset 5, low byte offset 4) for a packet slot and to 0x0000 for any other slot.
- R4: A drive/head write (offset 6) stores the written value ORed with 0xA0, and bit 4 selects slot 1. If the newly selected slot is empty, error bit 2 (abort) and status bit 0 (error) are also set.
- R5: Writes to offsets 2 to 5 (count, number, cylinder low, cylinder high) update the copies of both slots. Reads of these offsets return the copy of the selected slot.
- R6: While the selected slot is empty, a read of offset 6 returns 0xA0 and a read of offsets 0 to 5, 7 and 8 returns 0x00. Offset 9 always reads 0xFF. Offsets 10 to 15 read 0x00.
- R7: Offset 1 reads the error register. Offsets 7 and 8 both read the status register.
- R8: Command 0xEC to a disk slot, or 0xA1 to a packet slot, clears error and sets status to 0x58.
- R9: An identify command sent to a slot of the wrong type (empty included) resets that slot's count, number and cylinder as in R3 and leaves the other slot alone. It then aborts: status 0x41, error 0x04, interrupt.
- R10: Command 0xC6 stores the selected slot's sector count as its block size, with 0 stored as 1. It then sets status bit 6, clears status bit 0 and interrupts. A count above MAX_MULT aborts the command and keeps the old block size.
- R11: Commands 0xEF, 0x91 and 0x10 clear status bits 7, 5 and 0, set bits 6 and 4, and interrupt. Any other command value aborts as in R9.
- R12: The interrupt output is a one-cycle pulse in the cycle after a completing command write. It is suppressed while control bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register offset |
| wr_en_i | input | 1 | Write strobe, one byte per cycle |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational, zero when no read |
| slot0_type_i | input | 2 | Slot 0 device: 0 none, 1 disk, 2 packet, 3 none |
| slot1_type_i | input | 2 | Slot 1 device, same encoding |
| irq_o | output | 1 | Interrupt request pulse |
| cmd_o | output | 8 | Last command byte written |
| mult_blk_o | output | 8 | Block size of the selected slot |

## Verification
On every cycle the assertions check the following. An interrupt pulse needs interrupt enable and a command write in the cycle before. Alternate-address reads return 0xFF, and reads of an empty slot return their fixed values. Drive/head always carries its two fixed bits after a write, and both soft-reset edges produce their fixed status and error patterns. Only the bench scenarios can show the rest: which slot's copy a read returns, the per-slot signature reload after a wrong-type identify, how the block size is taken from the count, and that a repeated reset bit has no effect. These depend on sequences of writes followed by reads.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int unsigned NUM_SLOTS = 2;

  typedef enum logic [1:0] {
    DEV_NONE = 2'd0,
    DEV_DISK = 2'd1,
    DEV_PKT  = 2'd2,
    DEV_RSVD = 2'd3
  } dev_e;

  typedef enum logic [2:0] {
    ACT_ID_OK,
    ACT_ID_BAD,
    ACT_MULT,
    ACT_ACK,
    ACT_ABORT
  } act_e;

  localparam logic [3:0] OFF_DATA = 4'd0;
  localparam logic [3:0] OFF_ERR  = 4'd1;
  localparam logic [3:0] OFF_CNT  = 4'd2;
  localparam logic [3:0] OFF_NUM  = 4'd3;
  localparam logic [3:0] OFF_CYLL = 4'd4;
  localparam logic [3:0] OFF_CYLH = 4'd5;
  localparam logic [3:0] OFF_DH   = 4'd6;
  localparam logic [3:0] OFF_CMD  = 4'd7;
  localparam logic [3:0] OFF_CTRL = 4'd8;
  localparam logic [3:0] OFF_ALT  = 4'd9;

  localparam logic [7:0] CMD_IDENT   = 8'hEC;
  localparam logic [7:0] CMD_PIDENT  = 8'hA1;
  localparam logic [7:0] CMD_SETMULT = 8'hC6;
  localparam logic [7:0] CMD_SETFEAT = 8'hEF;
  localparam logic [7:0] CMD_INITP   = 8'h91;
  localparam logic [7:0] CMD_RECAL   = 8'h10;

  localparam logic [7:0] ST_RST    = 8'h90;
  localparam logic [7:0] ST_ID     = 8'h58;
  localparam logic [7:0] ST_ABORT  = 8'h41;
  localparam logic [7:0] ER_RST    = 8'h01;
  localparam logic [7:0] ER_ABORT  = 8'h04;
  localparam logic [7:0] DH_FIXED  = 8'hA0;
  localparam logic [15:0] PKT_SIG  = 16'hEB14;
endpackage

// File: rtl/ata_tf_slot.sv
module ata_tf_slot
  import ata_tf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [1:0]  sel_off_i,
  input  logic [7:0]  wdata_i,
  input  logic        sig_load_i,
  input  logic        is_pkt_i,
  input  logic        mult_wr_i,
  input  logic [7:0]  mult_val_i,
  output logic [7:0]  cnt_o,
  output logic [7:0]  num_o,
  output logic [15:0] cyl_o,
  output logic [7:0]  mult_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      num_o  <= '0;
      cyl_o  <= '0;
      mult_o <= 8'd1;
    end else begin
      if (sig_load_i) begin
        cnt_o <= 8'd1;
        num_o <= 8'd1;
        cyl_o <= is_pkt_i ? PKT_SIG : 16'h0000;
      end else if (wr_i) begin
        unique case (sel_off_i)
          2'd0: cnt_o        <= wdata_i;
          2'd1: num_o        <= wdata_i;
          2'd2: cyl_o[7:0]   <= wdata_i;
          2'd3: cyl_o[15:8]  <= wdata_i;
          default: ;
        endcase
      end
      if (mult_wr_i) mult_o <= mult_val_i;
    end
  end
endmodule

// File: rtl/ata_tf_cmd.sv
module ata_tf_cmd
  import ata_tf_pkg::*;
#(
  parameter int unsigned MAX_MULT = 16
) (
  input  logic [7:0] cmd_i,
  input  dev_e       dev_i,
  input  logic [7:0] cnt_i,
  output act_e       act_o,
  output logic [7:0] mult_o
);
  localparam logic [8:0] MaxW = 9'(MAX_MULT);

  always_comb begin
    act_o  = ACT_ABORT;
    mult_o = (cnt_i == 8'd0) ? 8'd1 : cnt_i;
    unique case (cmd_i)
      CMD_IDENT:   act_o = (dev_i == DEV_DISK) ? ACT_ID_OK : ACT_ID_BAD;
      CMD_PIDENT:  act_o = (dev_i == DEV_PKT) ? ACT_ID_OK : ACT_ID_BAD;
      CMD_SETMULT: act_o = ({1'b0, cnt_i} > MaxW) ? ACT_ABORT : ACT_MULT;
      CMD_SETFEAT, CMD_INITP, CMD_RECAL: act_o = ACT_ACK;
      default:     act_o = ACT_ABORT;
    endcase
  end
endmodule

// File: rtl/ata_tf_rdmux.sv
module ata_tf_rdmux
  import ata_tf_pkg::*;
(
  input  logic [3:0]  addr_i,
  input  logic        rd_en_i,
  input  logic        absent_i,
  input  logic [7:0]  stat_i,
  input  logic [7:0]  err_i,
  input  logic [7:0]  dh_i,
  input  logic [7:0]  cnt_i,
  input  logic [7:0]  num_i,
  input  logic [15:0] cyl_i,
  output logic [7:0]  rdata_o
);
  logic [7:0] d;

  always_comb begin
    unique case (addr_i)
      OFF_ERR:           d = err_i;
      OFF_CNT:           d = cnt_i;
      OFF_NUM:           d = num_i;
      OFF_CYLL:          d = cyl_i[7:0];
      OFF_CYLH:          d = cyl_i[15:8];
      OFF_DH:            d = dh_i;
      OFF_CMD, OFF_CTRL: d = stat_i;
      OFF_ALT:           d = 8'hFF;
      default:           d = 8'h00;
    endcase
    // empty slot masks every register except the alternate address
    if (absent_i && addr_i != OFF_ALT) d = (addr_i == OFF_DH) ? DH_FIXED : 8'h00;
  end

  assign rdata_o = rd_en_i ? d : 8'h00;
endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter int unsigned MAX_MULT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] addr_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic [1:0] slot0_type_i,
  input  logic [1:0] slot1_type_i,
  output logic       irq_o,
  output logic [7:0] cmd_o,
  output logic [7:0] mult_blk_o
);
  logic [7:0] stat_q, err_q, dh_q, cmd_q;
  logic       nien_q, srst_q, irq_q;

  dev_e        slot_type [NUM_SLOTS];
  logic        present   [NUM_SLOTS];
  logic [7:0]  s_cnt     [NUM_SLOTS];
  logic [7:0]  s_num     [NUM_SLOTS];
  logic [15:0] s_cyl     [NUM_SLOTS];
  logic [7:0]  s_mult    [NUM_SLOTS];
  logic        sig_load  [NUM_SLOTS];
  logic        mult_wr   [NUM_SLOTS];

  assign slot_type[0] = dev_e'(slot0_type_i);
  assign slot_type[1] = dev_e'(slot1_type_i);

  logic sel, sel_absent;
  assign sel        = dh_q[4];
  assign sel_absent = !present[sel];

  logic wr_ctrl, srst_rise, srst_fall, wr_cmd, wr_slot;
  assign wr_ctrl   = wr_en_i && (addr_i == OFF_CTRL);
  assign srst_rise = wr_ctrl && !srst_q && wdata_i[2];
  assign srst_fall = wr_ctrl && srst_q && !wdata_i[2];
  assign wr_cmd    = wr_en_i && (addr_i == OFF_CMD);
  assign wr_slot   = wr_en_i && (addr_i >= OFF_CNT) && (addr_i <= OFF_CYLH);

  act_e       act;
  logic [7:0] mult_val;

  ata_tf_cmd #(.MAX_MULT(MAX_MULT)) u_cmd (
    .cmd_i  (wdata_i),
    .dev_i  (slot_type[sel]),
    .cnt_i  (s_cnt[sel]),
    .act_o  (act),
    .mult_o (mult_val)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign present[s]  = (slot_type[s] == DEV_DISK) || (slot_type[s] == DEV_PKT);
    assign sig_load[s] = srst_fall || (wr_cmd && act == ACT_ID_BAD && sel == 1'(s));
    assign mult_wr[s]  = wr_cmd && act == ACT_MULT && sel == 1'(s);

    ata_tf_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_slot),
      .sel_off_i  (addr_i[1:0] - 2'd2),
      .wdata_i    (wdata_i),
      .sig_load_i (sig_load[s]),
      .is_pkt_i   (slot_type[s] == DEV_PKT),
      .mult_wr_i  (mult_wr[s]),
      .mult_val_i (mult_val),
      .cnt_o      (s_cnt[s]),
      .num_o      (s_num[s]),
      .cyl_o      (s_cyl[s]),
      .mult_o     (s_mult[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 8'h00;
      err_q  <= ER_RST;
      dh_q   <= 8'h00;
      cmd_q  <= 8'h00;
      nien_q <= 1'b0;
      srst_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_en_i) begin
        unique case (addr_i)
          OFF_DH: begin
            dh_q <= wdata_i | DH_FIXED;
            if (!present[wdata_i[4]]) begin
              err_q  <= err_q | ER_ABORT;
              stat_q <= stat_q | 8'h01;
            end
          end
          OFF_CMD: begin
            cmd_q <= wdata_i;
            irq_q <= !nien_q;
            unique case (act)
              ACT_ID_OK: begin
                err_q  <= 8'h00;
                stat_q <= ST_ID;
              end
              ACT_MULT: stat_q <= (stat_q | 8'h40) & ~8'h01;
              ACT_ACK:  stat_q <= (stat_q & ~8'hA1) | 8'h50;
              default: begin
                stat_q <= ST_ABORT;
                err_q  <= ER_ABORT;
              end
            endcase
          end
          OFF_CTRL: begin
            srst_q <= wdata_i[2];
            if (srst_rise) begin
              stat_q <= ST_RST;
              err_q  <= ER_RST;
              cmd_q  <= 8'h00;
              nien_q <= 1'b0;
            end else begin
              nien_q <= wdata_i[1];
              if (srst_fall) begin
                stat_q <= (stat_q & ~8'h80) | 8'h40;
                dh_q   <= dh_q & 8'hF0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  ata_tf_rdmux u_rd (
    .addr_i   (addr_i),
    .rd_en_i  (rd_en_i),
    .absent_i (sel_absent),
    .stat_i   (stat_q),
    .err_i    (err_q),
    .dh_i     (dh_q),
    .cnt_i    (s_cnt[sel]),
    .num_i    (s_num[sel]),
    .cyl_i    (s_cyl[sel]),
    .rdata_o  (rdata_o)
  );

  assign irq_o      = irq_q;
  assign cmd_o      = cmd_q;
  assign mult_blk_o = s_mult[sel];
endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] addr_i,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       irq_o,
  input logic       nien_q,
  input logic       srst_q,
  input logic [7:0] stat_q,
  input logic [7:0] err_q,
  input logic [7:0] dh_q,
  input logic       sel_absent
);
  a_r12_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !nien_q);

  a_r12_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(wr_en_i && addr_i == 4'd7));

  a_r6_alt_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 4'd9) |-> rdata_o == 8'hFF);

  a_r6_absent_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel_absent && addr_i <= 4'd8 && addr_i != 4'd6) |-> rdata_o == 8'h00);

  a_r4_dh_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'd6) |=> (dh_q[7] && dh_q[5]));

  a_r2_srst_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'd8 && !srst_q && wdata_i[2])
      |=> (stat_q == 8'h90 && err_q == 8'h01 && !nien_q));

  a_r3_srst_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'd8 && srst_q && !wdata_i[2])
      |=> (!stat_q[7] && stat_q[6] && dh_q[3:0] == 4'h0));
endmodule

bind ata_taskfile ata_taskfile_chk u_chk (.*);

// File: tb/tb_ata_taskfile.sv
module tb_ata_taskfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] t0 = 2'd1, t1 = 2'd2;
  logic       irq;
  logic [7:0] cmd_out, mult_blk;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    string      req;
    logic [3:0] off;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  ata_taskfile #(.MAX_MULT(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .slot0_type_i(t0), .slot1_type_i(t1),
    .irq_o(irq), .cmd_o(cmd_out), .mult_blk_o(mult_blk)
  );

  // monitor: compare each read against the queued expectation
  always @(negedge clk) begin
    if (rd_en) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expectation, actual %02h expected none", rdata);
      end else begin
        e = sb.pop_front();
        if (rdata !== e.exp) begin
          errors++;
          $display("FAIL %s: offset %0d actual %02h expected %02h", e.req, e.off, rdata, e.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string req);
    exp_t it;
    @(posedge clk); #1;
    it.exp = e; it.req = req; it.off = a;
    sb.push_back(it);
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] e, input string req);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, e);
    end
  endtask

  // command write; irq_o is sampled in the cycle after the write edge
  task automatic cmd(input logic [7:0] c, input logic e_irq, input string req);
    wr(4'd7, c);
    chk({7'd0, irq}, {7'd0, e_irq}, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 power-on state
    rd(4'd7, 8'h00, "R1 status");
    rd(4'd1, 8'h01, "R1 error");
    rd(4'd6, 8'h00, "R1 drive/head");
    chk(cmd_out, 8'h00, "R1 command");
    chk(mult_blk, 8'h01, "R1 block size");

    // R5 shared writes, per-slot reads
    wr(4'd2, 8'h05); wr(4'd3, 8'h11); wr(4'd4, 8'h22); wr(4'd5, 8'h33);
    rd(4'd2, 8'h05, "R5 count"); rd(4'd3, 8'h11, "R5 number");
    rd(4'd4, 8'h22, "R5 cyl low"); rd(4'd5, 8'h33, "R5 cyl high");
    wr(4'd6, 8'h10);
    rd(4'd6, 8'hB0, "R4 or 0xA0");
    rd(4'd2, 8'h05, "R5 slot1 copy");

    // R9 disk identify on packet slot
    cmd(8'hEC, 1'b1, "R9 irq");
    rd(4'd7, 8'h41, "R9 status"); rd(4'd1, 8'h04, "R9 error");
    rd(4'd2, 8'h01, "R9 count"); rd(4'd3, 8'h01, "R9 number");
    rd(4'd4, 8'h14, "R9 sig low"); rd(4'd5, 8'hEB, "R9 sig high");
    // R8 packet identify on packet slot
    cmd(8'hA1, 1'b1, "R8 irq packet");
    rd(4'd7, 8'h58, "R8 status packet"); rd(4'd1, 8'h00, "R8 error packet");
    wr(4'd6, 8'h00);
    rd(4'd6, 8'hA0, "R4 select slot0");
    rd(4'd2, 8'h05, "R9 other slot kept"); rd(4'd5, 8'h33, "R9 other slot kept");

    // R8 identify on disk slot
    cmd(8'hEC, 1'b1, "R8 irq disk");
    rd(4'd7, 8'h58, "R8 status"); rd(4'd1, 8'h00, "R8 error");
    rd(4'd8, 8'h58, "R7 status at control offset");

    // R10 set-multiple
    wr(4'd2, 8'h00);
    cmd(8'hC6, 1'b1, "R10 irq");
    chk(mult_blk, 8'h01, "R10 zero count");
    wr(4'd2, 8'h08);
    cmd(8'hC6, 1'b1, "R10 irq");
    chk(mult_blk, 8'h08, "R10 count 8");
    rd(4'd7, 8'h58, "R10 status");
    wr(4'd2, 8'd17);
    cmd(8'hC6, 1'b1, "R10 abort irq");
    chk(mult_blk, 8'h08, "R10 over max keeps size");
    rd(4'd7, 8'h41, "R10 abort status"); rd(4'd1, 8'h04, "R10 abort error");

    // R11 acknowledge and unknown commands
    cmd(8'hEF, 1'b1, "R11 irq");
    rd(4'd7, 8'h50, "R11 status");
    cmd(8'h30, 1'b1, "R11 unknown irq");
    rd(4'd7, 8'h41, "R11 unknown status");
    cmd(8'h91, 1'b1, "R11 irq 0x91");
    rd(4'd7, 8'h50, "R11 status 0x91");

    // R12 interrupt disabled
    wr(4'd8, 8'h02);
    cmd(8'hEC, 1'b0, "R12 masked");
    rd(4'd7, 8'h58, "R12 command still runs");
    chk(cmd_out, 8'hEC, "R12 command output");
    wr(4'd8, 8'h00);
    cmd(8'h10, 1'b1, "R12 unmasked");

    // R2 soft reset rise, with disable bit written as 1
    wr(4'd8, 8'h06);
    rd(4'd7, 8'h90, "R2 status"); rd(4'd1, 8'h01, "R2 error");
    chk(cmd_out, 8'h00, "R2 command cleared");
    cmd(8'hEF, 1'b1, "R2 disable cleared");
    rd(4'd7, 8'h50, "R2 status after ack");
    wr(4'd8, 8'h04);
    rd(4'd7, 8'h50, "R2 no repeat on level");
    wr(4'd6, 8'h13); wr(4'd2, 8'h44);

    // R3 soft reset fall
    wr(4'd8, 8'h00);
    rd(4'd7, 8'h50, "R3 status"); rd(4'd6, 8'hB0, "R3 head zero");
    rd(4'd2, 8'h01, "R3 count"); rd(4'd4, 8'h14, "R3 packet sig low");
    rd(4'd5, 8'hEB, "R3 packet sig high");
    wr(4'd6, 8'h00);
    rd(4'd3, 8'h01, "R3 disk number");
    rd(4'd4, 8'h00, "R3 disk cyl low"); rd(4'd5, 8'h00, "R3 disk cyl high");

    // R4 and R6 empty slot
    t1 = 2'd0;
    wr(4'd6, 8'h10);
    rd(4'd6, 8'hA0, "R6 drive/head absent");
    rd(4'd7, 8'h00, "R6 status absent"); rd(4'd1, 8'h00, "R6 error absent");
    rd(4'd2, 8'h00, "R6 count absent"); rd(4'd8, 8'h00, "R6 alt status absent");
    rd(4'd9, 8'hFF, "R6 alt address absent");
    wr(4'd6, 8'h00);
    rd(4'd1, 8'h05, "R4 abort bit"); rd(4'd7, 8'h51, "R4 error bit");
    rd(4'd9, 8'hFF, "R6 alt address");
    rd(4'd12, 8'h00, "R6 unused offset");

    @(posedge clk); #1;
    chk(8'(sb.size()), 8'h00, "scoreboard drained");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule